// File: doc/BRIEF.md
# Dual-Bank Byte-Addressed Memory

This block is a 16-bit memory made of two byte-wide storage banks, attached to a processor that addresses single bytes. The even bank holds the bytes whose address has bit 0 clear and always drives the low data lane. The odd bank holds the bytes whose address has bit 0 set and always drives the high data lane. A 16-bit word therefore spans one location in each bank at the same bank index.

Address bit 0 and an active-low high-byte enable together pick the banks for each access. Both banks enabled is an aligned word access. One bank enabled is a byte access on that bank's own lane. Neither enabled selects nothing. Writes land only in the enabled banks. Reads are registered: data appears one clock after the read strobe is sampled, and any lane whose bank is not enabled reads as zero. The bank depth is a parameter, so the bank index uses only the low address bits above bit 0, and the address bits above those alias.

Top module: `dual_bank_mem`

## Requirements
- R1: While `rstN` is low, `rdData` is 0.
- R2: A word access (`addr[0]`=0, `bheN`=0) writes `wrData[7:0]` to the even bank and `wrData[15:8]` to the odd bank at index `addr[IDX_W:1]`. A word read returns both bytes in those lanes.
- R3: An even-byte access (`addr[0]`=0, `bheN`=1) writes only the even bank, from `wrData[7:0]`. An even-byte read returns that byte on `rdData[7:0]` and 0 on `rdData[15:8]`.
- R4: An odd-byte access (`addr[0]`=1, `bheN`=0) writes only the odd bank, from `wrData[15:8]`. An odd-byte read returns that byte on `rdData[15:8]` and 0 on `rdData[7:0]`.
- R5: With `addr[0]`=1 and `bheN`=1, a write changes neither bank and a read returns 0.
- R6: A read sampled at a rising clock edge (`rdN`=0, `wrN`=1) updates `rdData` at that same edge. Back-to-back reads each take one cycle.
- R7: On an edge with no read sampled, `rdData` holds its value.
- R8: When `rdN` and `wrN` are both low, the write is performed and the read is ignored, so `rdData` holds.
- R9: Address bits above `IDX_W` are ignored. Two addresses that agree in bits `IDX_W:0` reach the same bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (20) | Byte address |
| bheN | input | 1 | High-byte (odd bank) enable, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| wrData | input | 16 | Write data; the even bank takes bits 7:0, the odd bank takes bits 15:8 |
| rdData | output | 16 | Registered read data |

## Verification
The bench mixes byte writes into locations that hold full words. It then reads those words back, which exposes a design that writes the disabled bank or puts a byte on the wrong lane. Byte reads and the no-bank combination check that the disabled lanes read zero and are not left stale. A cycle with both strobes low and an address far above the bank depth catch a design that lets the read win, or that decodes the index from the wrong bits. Idle cycles placed between reads catch an output that drifts or picks up a late value.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic [LANES-1:0] laneWe;   // lane 0 = even bank, lane 1 = odd bank
    logic [LANES-1:0] laneRd;   // lane enabled for the read result
    logic             capture;  // load the read result register
  } dbmCtrl_t;
endpackage

// File: rtl/dbm_ctrl.sv
module dbm_ctrl
  import dbm_pkg::*;
(
  input  logic     addrLsb,
  input  logic     bheN,
  input  logic     rdN,
  input  logic     wrN,
  output dbmCtrl_t ctrl
);
  logic [LANES-1:0] laneSel;
  logic             doWrite;
  logic             doRead;

  always_comb begin
    laneSel[0] = ~addrLsb;   // even bank on low lane
    laneSel[1] = ~bheN;      // odd bank on high lane
    doWrite    = ~wrN;
    doRead     = ~rdN & wrN; // a write takes priority over a read
    ctrl.laneWe  = laneSel & {LANES{doWrite}};
    ctrl.laneRd  = laneSel & {LANES{doRead}};
    ctrl.capture = doRead;
  end
endmodule

// File: rtl/dbm_bank.sv
module dbm_bank #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[idx] <= wdata;
  end

  assign rdata = store[idx];
endmodule

// File: rtl/dbm_datapath.sv
module dbm_datapath
  import dbm_pkg::*;
#(
  parameter int BANK_DEPTH = 256,
  localparam int IDX_W = $clog2(BANK_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dbmCtrl_t          ctrl,
  input  logic [IDX_W-1:0]  bankIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [LANE_W-1:0] laneQ [LANES];
  logic [DATA_W-1:0] nextRd;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    dbm_bank #(.WIDTH(LANE_W), .DEPTH(BANK_DEPTH)) bank_i (
      .clk   (clk),
      .we    (ctrl.laneWe[ln]),
      .idx   (bankIdx),
      .wdata (wrData[ln*LANE_W +: LANE_W]),
      .rdata (laneQ[ln])
    );
    assign nextRd[ln*LANE_W +: LANE_W] = ctrl.laneRd[ln] ? laneQ[ln] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (ctrl.capture) rdData <= nextRd;
  end
endmodule

// File: rtl/dual_bank_mem.sv
module dual_bank_mem
  import dbm_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BANK_DEPTH = 256,
  localparam int IDX_W = $clog2(BANK_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bheN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  dbmCtrl_t ctrl;

  dbm_ctrl ctrl_i (
    .addrLsb (addr[0]),
    .bheN    (bheN),
    .rdN     (rdN),
    .wrN     (wrN),
    .ctrl    (ctrl)
  );

  dbm_datapath #(.BANK_DEPTH(BANK_DEPTH)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .bankIdx (addr[IDX_W:1]),
    .wrData  (wrData),
    .rdData  (rdData)
  );
endmodule

// File: rtl/dbm_checker.sv
module dbm_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              bheN,
  input logic              rdN,
  input logic              wrN,
  input logic [15:0]       rdData
);
  logic readNow;
  assign readNow = !rdN && wrN;

  // R1: output is cleared while reset is held
  a_r1_reset_clear: assert property (@(posedge clk) !rstN |-> rdData == 16'h0);

  // R3: even-byte read leaves the high lane at zero
  a_r3_even_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    (readNow && !addr[0] && bheN) |=> rdData[15:8] == 8'h0);

  // R4: odd-byte read leaves the low lane at zero
  a_r4_odd_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (readNow && addr[0] && !bheN) |=> rdData[7:0] == 8'h0);

  // R5: a read that selects no bank returns zero
  a_r5_none_zero: assert property (@(posedge clk) disable iff (!rstN)
    (readNow && addr[0] && bheN) |=> rdData == 16'h0);

  // R7: no read sampled means the output holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdN && !wrN) || (rdN && wrN) |=> $stable(rdData));

  // R8: both strobes low, the read is ignored
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && !wrN) |=> $stable(rdData));
endmodule

bind dual_bank_mem dbm_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .addr   (addr),
  .bheN   (bheN),
  .rdN    (rdN),
  .wrN    (wrN),
  .rdData (rdData)
);

// File: tb/dual_bank_mem_tb.sv
module dual_bank_mem_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int DEPTH      = 256;
  localparam int IDXW       = $clog2(DEPTH);

  typedef struct {
    int          due;
    logic [15:0] val;
    string       tag;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN;
  logic [ADDR_W-1:0] addr;
  logic              bheN, rdN, wrN;
  logic [15:0]       wrData;
  logic [15:0]       rdData;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [7:0]  evenM [DEPTH];
  logic [7:0]  oddM  [DEPTH];
  logic [15:0] lastExp = 16'h0;
  expItem_t    scoreQ [$];

  dual_bank_mem #(.ADDR_W(ADDR_W), .BANK_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .bheN(bheN),
    .rdN(rdN), .wrN(wrN), .wrData(wrData), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare results that fall due in this cycle
  always @(negedge clk) begin
    while (scoreQ.size() > 0 && scoreQ[0].due == cyc) begin
      expItem_t it;
      it = scoreQ.pop_front();
      checks++;
      if (rdData !== it.val) begin
        fails++;
        $display("FAIL %s: rdData=%h expected=%h (cycle %0d)", it.tag, rdData, it.val, cyc);
      end
    end
  end

  // Driver: one access per cycle, expected value pushed to the scoreboard
  task automatic access(input bit doRd, input bit doWr, input logic [ADDR_W-1:0] a,
                        input logic bhe, input logic [15:0] d, input string tag);
    int idx;
    expItem_t it;
    @(negedge clk);
    addr = a; bheN = bhe; rdN = !doRd; wrN = !doWr; wrData = d;
    idx = int'(a[IDXW:1]);
    if (doWr) begin
      if (!a[0]) evenM[idx] = d[7:0];
      if (!bhe)  oddM[idx]  = d[15:8];
    end else if (doRd) begin
      lastExp = {(!bhe ? oddM[idx] : 8'h0), (!a[0] ? evenM[idx] : 8'h0)};
    end
    it.due = cyc + 1;
    it.val = lastExp;
    it.tag = tag;
    scoreQ.push_back(it);
  endtask

  task automatic idle(input string tag);
    access(1'b0, 1'b0, '0, 1'b1, 16'h0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; addr = '0; bheN = 1'b1; rdN = 1'b1; wrN = 1'b1; wrData = '0;
    for (int i = 0; i < DEPTH; i++) begin evenM[i] = 8'h0; oddM[i] = 8'h0; end
    repeat (3) @(negedge clk);
    checks++;
    if (rdData !== 16'h0) begin
      fails++;
      $display("FAIL R1: rdData=%h expected=0000", rdData);
    end
    rstN = 1'b1;

    // R2: fill indices 0..15 with words
    for (int i = 0; i < 16; i++)
      access(1'b0, 1'b1, ADDR_W'(i*2), 1'b0, 16'hA050 + 16'(i*16'h0101), "R2");
    // R2, R6: back-to-back word reads
    for (int i = 0; i < 16; i += 3)
      access(1'b1, 1'b0, ADDR_W'(i*2), 1'b0, 16'h0, "R6");

    // R3: even-byte write, then word and even-byte reads
    access(1'b0, 1'b1, 20'h00004, 1'b1, 16'h5A3C, "R3");
    access(1'b1, 1'b0, 20'h00004, 1'b0, 16'h0, "R3");
    access(1'b1, 1'b0, 20'h00004, 1'b1, 16'h0, "R3");

    // R4: odd-byte write, then word and odd-byte reads
    access(1'b0, 1'b1, 20'h00007, 1'b0, 16'hC711, "R4");
    access(1'b1, 1'b0, 20'h00006, 1'b0, 16'h0, "R4");
    access(1'b1, 1'b0, 20'h00007, 1'b0, 16'h0, "R4");

    // R5: no bank selected
    access(1'b0, 1'b1, 20'h00009, 1'b1, 16'hFFFF, "R5");
    access(1'b1, 1'b0, 20'h00008, 1'b0, 16'h0, "R5");
    access(1'b1, 1'b0, 20'h00009, 1'b1, 16'h0, "R5");

    // R7: idle cycles after a word read
    access(1'b1, 1'b0, 20'h00002, 1'b0, 16'h0, "R7");
    idle("R7");
    idle("R7");

    // R8: both strobes low, write performed, read ignored
    access(1'b1, 1'b1, 20'h0000A, 1'b0, 16'h1234, "R8");
    idle("R8");
    access(1'b1, 1'b0, 20'h0000A, 1'b0, 16'h0, "R8");

    // R9: high address bits alias onto the same index
    access(1'b1, 1'b0, 20'hF0002, 1'b0, 16'h0, "R9");
    access(1'b0, 1'b1, 20'h80A0E, 1'b0, 16'hBEEF, "R9");
    access(1'b1, 1'b0, 20'h0000E, 1'b0, 16'h0, "R9");
    access(1'b1, 1'b0, 20'h3FE0F, 1'b0, 16'h0, "R9");

    idle("R7");
    idle("R7");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule